// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block forms the signed product of two N-bit two's complement operands. It works one multiplier bit per clock cycle and returns a 2N-bit signed result. A single start pulse captures both operands. The block then spends exactly N cycles working and marks completion with a one-cycle done pulse. The product stays on its output until the next accepted start.

Storage is three N-bit registers: a fixed multiplicand, an accumulator and a multiplier register. As the multiplier bits are consumed, the multiplier register fills from the top with the low half of the product. Each step uses one (N+1)-bit sign-extended adder/subtractor. It adds the multiplicand on the ordinary bit positions and subtracts it on the multiplier's sign bit, which carries negative weight. After each step the accumulator and the multiplier register shift right together as one arithmetic pair.

Top module: `shift_add_mult`

## Requirements
- R1: After reset, product is all zeros and busy and done are both 0.
- R2: A start pulse seen while the block is idle makes busy read 1 in the following cycle.
- R3: A multiplication takes exactly N cycles. The start is sampled at edge 0, and done reads 1 and busy reads 0 after edge N. After edge N-1, busy is still 1 and done is 0.
- R4: The product, read as a signed 2N-bit value, equals the signed product of the captured multiplicand and multiplier. This holds for every pair of operands.
- R5: When the multiplier is negative (its bit N-1 is 1), that bit is weighted -2^(N-1), and the result still matches the signed product.
- R6: With both operands at the most negative value -2^(N-1), the product is exactly +2^(2N-2). For the default N=8, this is 16'h4000.
- R7: A start pulse that arrives while busy has no effect. The run in progress finishes at its original cycle and returns the product of its original operands.
- R8: When the block is idle and start is low, the product does not change.
- R9: done is high for exactly one cycle per multiplication.
- R10: The operands are sampled only on the accepted start. Changes to the operand inputs during a run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a multiplication |
| mcand_in | input | N | Signed multiplicand operand |
| mplier_in | input | N | Signed multiplier operand |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product (accumulator high, multiplier register low) |

## Verification
The bench sweeps every operand pair at N=4. At N=8 it drives the corner values (most negative, -1, 0, +1, most positive) against each other, plus random pairs. If the last step added instead of subtracting, every negative multiplier would give a wrong result. If the shift were logical rather than arithmetic, negative partial sums would lose their sign. Dropping the adder's carry bit would break the most-negative-squared case. Each run also scrambles the operand inputs after start, and one run pulses start mid-run. These catch a block that samples its operands late or restarts while busy. Done and busy are sampled one cycle before and at the expected finishing edge, which catches a step counter that is off by one.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;
endpackage

// File: rtl/mult_addsub.sv
// Sign-extended (W+1)-bit adder/subtractor: sum = a +/- b without overflow.
module mult_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W:0]   sum
);
    logic [W:0] a_ext;
    logic [W:0] b_ext;
    logic [W:0] b_inv;

    always_comb begin
        a_ext = {a[W-1], a};
        b_ext = {b[W-1], b};
        b_inv = sub ? ~b_ext : b_ext;
        sum   = a_ext + b_inv + {{W{1'b0}}, sub};
    end
endmodule

// File: rtl/mult_step_ctr.sv
// Step counter: cleared on start, advanced once per working cycle.
module mult_step_ctr #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic last
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(N - 1));
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
    import shift_add_mult_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand_in,
    input  logic [N-1:0]   mplier_in,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int PW = 2 * N;

    typedef struct packed {
        mul_state_e   st;
        logic [N-1:0] mcand;
        logic [N-1:0] acc;
        logic [N-1:0] mpr;
        logic         done;
    } regs_t;

    regs_t      r_d, r_q;
    logic       ctr_clr;
    logic       ctr_en;
    logic       step_last;
    logic [N:0] sum_w;
    logic [N:0] ext;

    mult_step_ctr #(.N(N)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .en    (ctr_en),
        .last  (step_last)
    );

    // On the final step the examined bit is the sign bit: subtract.
    mult_addsub #(.W(N)) u_addsub (
        .a   (r_q.acc),
        .b   (r_q.mcand),
        .sub (step_last),
        .sum (sum_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ctr_clr  = 1'b0;
        ctr_en   = 1'b0;
        ext      = {r_q.acc[N-1], r_q.acc};
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_RUN;
                    r_d.mcand = mcand_in;
                    r_d.acc   = '0;
                    r_d.mpr   = mplier_in;
                    ctr_clr   = 1'b1;
                end
            end
            ST_RUN: begin
                ctr_en = 1'b1;
                if (r_q.mpr[0])
                    ext = sum_w;
                // arithmetic right shift of the {acc, mpr} pair
                r_d.acc = ext[N:1];
                r_d.mpr = {ext[0], r_q.mpr[N-1:1]};
                if (step_last) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.mcand <= '0;
            r_q.acc   <= '0;
            r_q.mpr   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st == ST_RUN);
    assign done    = r_q.done;
    assign product = PW'({r_q.acc, r_q.mpr});
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int RW = $clog2(N) + 2;

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (busy)
            run_cnt <= run_cnt + 1'b1;
        else
            run_cnt <= '0;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt == RW'(N - 1)) |=> (!busy && done));

    p_no_extend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt <= RW'(N - 1)));

    p_done_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind shift_add_mult shift_add_mult_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/shift_add_mult_tb.sv
module shift_add_mult_tb;
    localparam int NA = 4;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            start_a = 1'b0, start_b = 1'b0;
    logic [NA-1:0]   mc_a = '0, mp_a = '0;
    logic [NB-1:0]   mc_b = '0, mp_b = '0;
    logic            busy_a, done_a, busy_b, done_b;
    logic [2*NA-1:0] prod_a;
    logic [2*NB-1:0] prod_b;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    shift_add_mult #(.N(NA)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start_a), .mcand_in(mc_a),
        .mplier_in(mp_a), .busy(busy_a), .done(done_a), .product(prod_a)
    );

    shift_add_mult #(.N(NB)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .start(start_b), .mcand_in(mc_b),
        .mplier_in(mp_b), .busy(busy_b), .done(done_b), .product(prod_b)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_a(input logic [NA-1:0] a, input logic [NA-1:0] b, input bit poke);
        int exp_v;
        int act_v;
        logic [2*NA-1:0] held;
        string tag;
        @(negedge clk);
        mc_a = a; mp_a = b; start_a = 1'b1;
        @(negedge clk);
        start_a = poke;
        mc_a = ~a; mp_a = b ^ 4'h5;          // R10 scramble after capture
        chk(busy_a === 1'b1, "R2", busy_a, 1);
        for (int i = 0; i < NA - 1; i++) begin
            @(negedge clk);
            start_a = 1'b0;
        end
        chk(busy_a === 1'b1 && done_a === 1'b0, poke ? "R7" : "R3", {busy_a, done_a}, 2);
        @(negedge clk);
        chk(done_a === 1'b1 && busy_a === 1'b0, "R3", {busy_a, done_a}, 1);
        exp_v = int'($signed(a)) * int'($signed(b));
        act_v = int'($signed(prod_a));
        if (a == 4'h8 && b == 4'h8) tag = "R6";
        else if (poke)              tag = "R7";
        else if (b[NA-1])           tag = "R5";
        else                        tag = "R4/R10";
        chk(act_v == exp_v, tag, act_v, exp_v);
        held = prod_a;
        @(negedge clk);
        chk(done_a === 1'b0, "R9", done_a, 0);
        chk(prod_a === held, "R8", prod_a, held);
    endtask

    task automatic run_b(input logic [NB-1:0] a, input logic [NB-1:0] b, input bit poke);
        longint exp_v;
        longint act_v;
        string tag;
        @(negedge clk);
        mc_b = a; mp_b = b; start_b = 1'b1;
        @(negedge clk);
        start_b = poke;
        mc_b = a ^ 8'hA5; mp_b = ~b;         // R10 scramble after capture
        chk(busy_b === 1'b1, "R2", busy_b, 1);
        for (int i = 0; i < NB - 1; i++) begin
            @(negedge clk);
            start_b = 1'b0;
        end
        chk(busy_b === 1'b1 && done_b === 1'b0, poke ? "R7" : "R3", {busy_b, done_b}, 2);
        @(negedge clk);
        chk(done_b === 1'b1 && busy_b === 1'b0, "R3", {busy_b, done_b}, 1);
        exp_v = longint'($signed(a)) * longint'($signed(b));
        act_v = longint'($signed(prod_b));
        if (a == 8'h80 && b == 8'h80) begin
            tag = "R6";
            chk(prod_b === 16'h4000, "R6", prod_b, 16'h4000);
        end
        else if (poke)    tag = "R7";
        else if (b[NB-1]) tag = "R5";
        else              tag = "R4/R10";
        chk(act_v == exp_v, tag, act_v, exp_v);
        @(negedge clk);
        chk(done_b === 1'b0, "R9", done_b, 0);
    endtask

    initial begin
        logic [NB-1:0] corners [6];
        corners[0] = 8'h80; corners[1] = 8'hFF; corners[2] = 8'h00;
        corners[3] = 8'h7F; corners[4] = 8'h01; corners[5] = 8'h81;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(prod_a === '0 && busy_a === 1'b0 && done_a === 1'b0, "R1", prod_a, 0);
        chk(prod_b === '0 && busy_b === 1'b0 && done_b === 1'b0, "R1", prod_b, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prod_a === '0 && busy_a === 1'b0, "R1", prod_a, 0);

        // exhaustive sweep for the small configuration
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                run_a(4'(x), 4'(y), 1'b0);

        // start while busy is ignored (R7)
        run_a(4'h8, 4'h3, 1'b1);
        run_a(4'h7, 4'hB, 1'b1);
        run_b(8'h9C, 8'h65, 1'b1);

        // corner pairs for the wide configuration
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                run_b(corners[i], corners[j], 1'b0);

        // random pairs
        for (int k = 0; k < 200; k++)
            run_b(8'($urandom), 8'($urandom), 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule